// File: doc/BRIEF.md
# Daisy-Chain Output Frame Sender

This block sits on the host side of a chain of serial-to-parallel output devices. Each device holds 12 channels, and `N_DEV` devices are wired in series. The block takes a whole parallel frame of `12*N_DEV` bits through a start/busy handshake. It shifts the frame out on a serial clock and data pair, then raises a latch strobe so that every device in the chain moves its shift stage to its outputs at the same moment. The block also drives the reset line of the chain. That line stays asserted from system reset until the block is ready, so no output can light by accident at start-up.

All serial timing is derived from the system clock. Each timing floor is given as a parameter in nanoseconds: serial clock high time, low time and period, data setup and hold, the gap from the last clock edge to the latch, the latch high time, the idle time after the latch, and the power-up hold. Each floor is rounded up to whole system cycles. The most significant frame bit goes out first, so the bits for the device farthest from the host lead the frame. With the default 50 MHz system clock the derived counts are:

| Interval | Cycles |
|---|---|
| Clock high | 19 |
| Clock low | 21 |
| Clock period | 40 |
| Setup | 8 |
| Hold | 8 |
| Last edge to latch | 10 |
| Latch high | 19 |
| Trailing low | 19 |
| Power-up hold | 50 |

Top module: `chain_frame_tx`

## Requirements
- R1: After system reset, `chain_rst_n` stays low and `busy` high for 50 system cycles, with `ser_clk`, `ser_data`, `ser_latch` and `done` all low. Then `chain_rst_n` goes high and `busy` goes low.
- R2: After a frame, the bits sampled on the rising edges of `ser_clk`, taken in order, equal `frame_in` as it was at acceptance. Bit 23 (the farthest device's top channel) goes first and bit 0 goes last.
- R3: Each frame has exactly `12*N_DEV` rising edges of `ser_clk` (24 by default) before the latch.
- R4: Each `ser_clk` high phase lasts at least 19 cycles. Each low phase between two rising edges of a frame lasts at least 21 cycles. Rising edges are at least 40 cycles apart.
- R5: `ser_data` is stable for at least 8 cycles before each rising edge of `ser_clk`, and it changes only while `ser_clk` is low.
- R6: `ser_data` holds for at least 8 cycles after each rising edge of `ser_clk`.
- R7: `ser_latch` pulses exactly once per frame. It rises at least 10 cycles after the last rising edge of `ser_clk`, stays high for at least 19 cycles, and is never high together with `ser_clk`.
- R8: `busy` rises in the cycle after a start is accepted. It stays high until the latch has been low for at least 19 cycles. `done` is then high for exactly one cycle, in the first cycle with `busy` low.
- R9: A `start` raised while `busy` is high is ignored. The frame in flight is unchanged, and no second frame follows once it completes.
- R10: While `busy` is low, `ser_clk` and `ser_latch` are low.
- R11: `frame_in` is captured when start is accepted. Changes to it while busy have no effect on the bits sent.
- R12: A `start` that is high in the cycle `done` is high is accepted, and the next frame begins at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to send `frame_in`; taken only when not busy |
| frame_in | input | 12*N_DEV | Parallel frame; bit 23 is sent first |
| busy | output | 1 | High during power-up hold and while a frame is in flight |
| done | output | 1 | One-cycle end-of-frame pulse |
| ser_clk | output | 1 | Serial shift clock to the chain |
| ser_data | output | 1 | Serial data to the first device |
| ser_latch | output | 1 | Transfer strobe to all devices |
| chain_rst_n | output | 1 | Active-low reset to the chain |

## Verification
Two events can land in the same cycle: the end-of-frame pulse and a new start request. The block returns to idle in the same cycle that `done` is high, so a start present then must launch the next frame, while a start raised one cycle earlier, during the trailing low time, must be dropped. The bench holds `start` high across the end of a frame and changes `frame_in` during the first frame. It judges the outcome by the serial waveform alone: `busy` must fall for exactly one cycle, and the second delivered frame must carry the new word. A separate run pulses start in mid-frame and checks that the frame is neither corrupted nor repeated.

// File: rtl/cft_pkg.sv
package cft_pkg;

   typedef enum logic [2:0] {
      ST_PWR,
      ST_IDLE,
      ST_LEAD,
      ST_HIGH,
      ST_LOWA,
      ST_GAP,
      ST_LATCH,
      ST_TAIL
   } cft_state_t;

   // Round a nanosecond floor up to whole system cycles.
   function automatic int ns_to_cyc(input int ns, input int khz);
      longint prod;
      prod = longint'(ns) * longint'(khz);
      return int'((prod + longint'(999_999)) / longint'(1_000_000));
   endfunction

   function automatic int max_i(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/cft_timer.sv
module cft_timer #(
   parameter int W    = 8,
   parameter int INIT = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic [W-1:0] cnt,
   output logic         zero
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= W'(INIT);
      else if (load)
         cnt <= load_val;
      else if (dec && (cnt != '0))
         cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/cft_shreg.sv
module cft_shreg #(
   parameter int W       = 24,
   parameter bit MSB_OUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift,
   output logic         bit_out
);

   logic [W-1:0] sh_q;

   generate
      if (MSB_OUT) begin : g_msb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     sh_q <= '0;
            else if (load)  sh_q <= load_val;
            else if (shift) sh_q <= {sh_q[W-2:0], 1'b0};
         end
         assign bit_out = sh_q[W-1];
      end else begin : g_lsb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     sh_q <= '0;
            else if (load)  sh_q <= load_val;
            else if (shift) sh_q <= {1'b0, sh_q[W-1:1]};
         end
         assign bit_out = sh_q[0];
      end
   endgenerate

endmodule

// File: rtl/chain_frame_tx.sv
module chain_frame_tx
   import cft_pkg::*;
#(
   parameter int N_DEV        = 2,
   parameter int CH_PER_DEV   = 12,
   parameter int SYS_CLK_KHZ  = 50_000,
   parameter int CLK_PER_NS   = 800,
   parameter int CLK_HI_NS    = 380,
   parameter int CLK_LO_NS    = 380,
   parameter int SETUP_NS     = 150,
   parameter int HOLD_NS      = 150,
   parameter int GAP_NS       = 200,
   parameter int LATCH_HI_NS  = 380,
   parameter int LATCH_LO_NS  = 380,
   parameter int PWRUP_NS     = 1000
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic [N_DEV*CH_PER_DEV-1:0]   frame_in,
   output logic                          busy,
   output logic                          done,
   output logic                          ser_clk,
   output logic                          ser_data,
   output logic                          ser_latch,
   output logic                          chain_rst_n
);

   localparam int FRAME_W = N_DEV * CH_PER_DEV;
   localparam int T_HI    = max_i(1, ns_to_cyc(CLK_HI_NS, SYS_CLK_KHZ));
   localparam int T_SU    = max_i(1, ns_to_cyc(SETUP_NS, SYS_CLK_KHZ));
   localparam int T_HD    = ns_to_cyc(HOLD_NS, SYS_CLK_KHZ);
   localparam int T_LO    = max_i(max_i(ns_to_cyc(CLK_LO_NS, SYS_CLK_KHZ),
                                        ns_to_cyc(CLK_PER_NS, SYS_CLK_KHZ) - T_HI),
                                  max_i(T_SU + T_HD, T_SU + 1));
   localparam int T_LOA   = T_LO - T_SU;
   localparam int T_GAP   = max_i(1, ns_to_cyc(GAP_NS, SYS_CLK_KHZ));
   localparam int T_LH    = max_i(1, ns_to_cyc(LATCH_HI_NS, SYS_CLK_KHZ));
   localparam int T_LL    = max_i(1, ns_to_cyc(LATCH_LO_NS, SYS_CLK_KHZ));
   localparam int T_RST   = max_i(1, ns_to_cyc(PWRUP_NS, SYS_CLK_KHZ));
   localparam int T_MAX   = max_i(max_i(max_i(T_HI, T_LO), max_i(T_GAP, T_LH)),
                                  max_i(T_LL, T_RST));
   localparam int TW      = $clog2(T_MAX + 1);
   localparam int BW      = $clog2(FRAME_W + 1);

   // Elaboration-time parameter checks
   generate
      if (N_DEV < 1 || CH_PER_DEV < 1) begin : g_bad_size
         $error("chain_frame_tx: N_DEV and CH_PER_DEV must be positive");
      end
      if (SYS_CLK_KHZ < 1) begin : g_bad_clk
         $error("chain_frame_tx: SYS_CLK_KHZ must be positive");
      end
      if (T_LOA < T_HD || T_LOA < 1) begin : g_bad_low
         $error("chain_frame_tx: low phase cannot hold data long enough");
      end
   endgenerate

   cft_state_t   st, st_nx;
   logic         tm_load;
   logic [TW-1:0] tm_val;
   logic [TW-1:0] tm_cnt;
   logic         tm_zero;
   logic         bc_load, bc_dec;
   logic [BW-1:0] bc_cnt;
   logic         bc_zero;
   logic         sh_load, sh_shift;

   // Phase timer: starts counting the power-up hold straight out of reset.
   cft_timer #(.W(TW), .INIT(T_RST - 1)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tm_load),
      .load_val (tm_val),
      .dec      (1'b1),
      .cnt      (tm_cnt),
      .zero     (tm_zero)
   );

   // Bits remaining in the frame.
   cft_timer #(.W(BW), .INIT(0)) u_bits (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (bc_load),
      .load_val (BW'(FRAME_W)),
      .dec      (bc_dec),
      .cnt      (bc_cnt),
      .zero     (bc_zero)
   );

   // Farthest device's bits lead: shift out from the top of the word.
   cft_shreg #(.W(FRAME_W), .MSB_OUT(1'b1)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (sh_load),
      .load_val (frame_in),
      .shift    (sh_shift),
      .bit_out  (ser_data)
   );

   always_comb begin
      st_nx    = st;
      tm_load  = 1'b0;
      tm_val   = '0;
      bc_load  = 1'b0;
      bc_dec   = 1'b0;
      sh_load  = 1'b0;
      sh_shift = 1'b0;
      case (st)
         ST_PWR: begin
            if (tm_zero) st_nx = ST_IDLE;
         end
         ST_IDLE: begin
            if (start) begin
               sh_load = 1'b1;
               bc_load = 1'b1;
               tm_load = 1'b1;
               tm_val  = TW'(T_SU - 1);
               st_nx   = ST_LEAD;
            end
         end
         ST_LEAD: begin
            if (tm_zero) begin
               tm_load = 1'b1;
               tm_val  = TW'(T_HI - 1);
               st_nx   = ST_HIGH;
            end
         end
         ST_HIGH: begin
            if (tm_zero) begin
               bc_dec  = 1'b1;
               tm_load = 1'b1;
               if (bc_cnt == BW'(1)) begin
                  tm_val = TW'(T_GAP - 1);
                  st_nx  = ST_GAP;
               end else begin
                  tm_val = TW'(T_LOA - 1);
                  st_nx  = ST_LOWA;
               end
            end
         end
         ST_LOWA: begin
            if (tm_zero) begin
               sh_shift = 1'b1;
               tm_load  = 1'b1;
               tm_val   = TW'(T_SU - 1);
               st_nx    = ST_LEAD;
            end
         end
         ST_GAP: begin
            if (tm_zero) begin
               tm_load = 1'b1;
               tm_val  = TW'(T_LH - 1);
               st_nx   = ST_LATCH;
            end
         end
         ST_LATCH: begin
            if (tm_zero) begin
               tm_load = 1'b1;
               tm_val  = TW'(T_LL - 1);
               st_nx   = ST_TAIL;
            end
         end
         ST_TAIL: begin
            if (tm_zero) st_nx = ST_IDLE;
         end
         default: st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_PWR;
         ser_clk     <= 1'b0;
         ser_latch   <= 1'b0;
         done        <= 1'b0;
         chain_rst_n <= 1'b0;
      end else begin
         st          <= st_nx;
         ser_clk     <= (st_nx == ST_HIGH);
         ser_latch   <= (st_nx == ST_LATCH);
         done        <= (st == ST_TAIL) && (st_nx == ST_IDLE);
         chain_rst_n <= (st_nx != ST_PWR);
      end
   end

   assign busy = (st != ST_IDLE);

   logic unused_ok;
   assign unused_ok = &{1'b0, bc_zero};

endmodule

// File: rtl/cft_chk.sv
module cft_chk #(
   parameter int T_HI_C = 1
) (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic done,
   input logic ser_clk,
   input logic ser_data,
   input logic ser_latch,
   input logic chain_rst_n
);

   logic [15:0] hi_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hi_len <= '0;
      else if (ser_clk) hi_len <= hi_len + 1'b1;
      else              hi_len <= '0;
   end

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!ser_clk && !ser_latch));

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R6
   hold_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_clk) |=> $stable(ser_data));

   // R5
   data_moves_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ser_data) |-> (!ser_clk && !$past(ser_clk)));

   // R7
   latch_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ser_latch |-> !ser_clk);

   // R1
   pwr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chain_rst_n |-> (busy && !ser_clk && !ser_latch));

   // R4
   high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_clk) |-> (hi_len >= 16'(T_HI_C)));

endmodule

bind chain_frame_tx cft_chk #(.T_HI_C(T_HI)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy        (busy),
   .done        (done),
   .ser_clk     (ser_clk),
   .ser_data    (ser_data),
   .ser_latch   (ser_latch),
   .chain_rst_n (chain_rst_n)
);

// File: tb/sim_chain_frame_tx.sv
module sim_chain_frame_tx;

   localparam int CLK_PERIOD_NS = 20;
   localparam int FW    = 24;
   localparam int E_HI  = 19;
   localparam int E_LO  = 21;
   localparam int E_PER = 40;
   localparam int E_SU  = 8;
   localparam int E_HD  = 8;
   localparam int E_GAP = 10;
   localparam int E_LH  = 19;
   localparam int E_LL  = 19;
   localparam int E_RST = 50;
   localparam int NV    = 6;
   localparam int BIG   = 1_000_000;

   // {mid-frame disturbance, frame}
   localparam logic [FW:0] VEC [NV] = '{
      {1'b0, 24'hA5C3F0},
      {1'b0, 24'h000001},
      {1'b0, 24'h800000},
      {1'b1, 24'hFFFFFF},
      {1'b0, 24'h000000},
      {1'b1, 24'h5A0F69}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [FW-1:0] frame_in = '0;
   logic busy, done, ser_clk, ser_data, ser_latch, chain_rst_n;

   int checks = 0;
   int errors = 0;

   chain_frame_tx u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .frame_in(frame_in),
      .busy(busy), .done(done), .ser_clk(ser_clk), .ser_data(ser_data),
      .ser_latch(ser_latch), .chain_rst_n(chain_rst_n)
   );

   always #(CLK_PERIOD_NS/2) clk = ~clk;

   // Waveform monitor
   logic p_clk, p_dat, p_lat, p_done, hold_pend;
   int since_dat, since_rise, since_prev, since_lfall, hi_len, lo_len, lat_len;
   int rises, min_su, min_hd, min_hi, min_lo, min_per, gap, lat_hi, latches, dones, tail;
   logic [FW-1:0] sr;

   task automatic clear_meas();
      rises = 0; min_su = BIG; min_hd = BIG; min_hi = BIG; min_lo = BIG;
      min_per = BIG; gap = -1; lat_hi = -1; latches = 0; dones = 0; tail = -1;
      sr = '0; hold_pend = 1'b0;
   endtask

   initial clear_meas();

   always @(negedge clk) begin
      if (!rst_n) begin
         p_clk = 0; p_dat = 0; p_lat = 0; p_done = 0;
         since_dat = BIG; since_rise = BIG; since_prev = BIG; since_lfall = BIG;
         hi_len = 0; lo_len = 0; lat_len = 0;
      end else begin
         since_dat++; since_rise++; since_prev++; since_lfall++;
         if (ser_data != p_dat) begin
            if (hold_pend && since_rise < min_hd) min_hd = since_rise;
            hold_pend = 1'b0;
            since_dat = 0;
         end
         if (!ser_clk && p_clk) begin
            if (hi_len < min_hi) min_hi = hi_len;
            lo_len = 0;
         end
         if (ser_clk && !p_clk) begin
            if (since_dat < min_su) min_su = since_dat;
            if (rises > 0 && lo_len < min_lo) min_lo = lo_len;
            if (rises > 0 && since_prev < min_per) min_per = since_prev;
            rises++;
            sr = {sr[FW-2:0], ser_data};
            since_rise = 0; since_prev = 0; hold_pend = 1'b1; hi_len = 0;
         end
         if (ser_clk) hi_len++; else lo_len++;
         if (ser_latch && !p_lat) begin
            latches++; gap = since_rise; lat_len = 0;
         end
         if (ser_latch) lat_len++;
         if (!ser_latch && p_lat) begin
            lat_hi = lat_len; since_lfall = 0;
         end
         if (done && !p_done) tail = since_lfall;
         if (done) dones++;
         p_clk = ser_clk; p_dat = ser_data; p_lat = ser_latch; p_done = done;
      end
   end

   task automatic tick();
      @(negedge clk); #1;
   endtask

   task automatic chk(input bit ok, input string what, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic check_frame(input logic [FW-1:0] f);
      chk(rises == FW, "R3 rising edges per frame", rises, FW);
      chk(sr == f, "R2 R11 delivered bits", sr, f);
      chk(min_su >= E_SU, "R5 setup cycles", min_su, E_SU);
      chk(min_hd >= E_HD, "R6 hold cycles", min_hd, E_HD);
      chk(min_hi >= E_HI, "R4 high cycles", min_hi, E_HI);
      chk(min_lo >= E_LO, "R4 low cycles", min_lo, E_LO);
      chk(min_per >= E_PER, "R4 period cycles", min_per, E_PER);
      chk(latches == 1, "R7 latch pulses", latches, 1);
      chk(gap >= E_GAP, "R7 edge to latch", gap, E_GAP);
      chk(lat_hi >= E_LH, "R7 latch width", lat_hi, E_LH);
      chk(tail >= E_LL, "R8 trailing low", tail, E_LL);
      chk(dones == 1 && !busy, "R8 done pulse", dones, 1);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (150_000) @(posedge clk);
      errors++;
      $display("FAIL R8 watchdog: actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      // R1: reset state and power-up hold
      repeat (3) tick();
      chk(!ser_clk && !ser_latch && !ser_data && !done, "R1 quiet in reset",
          {ser_clk, ser_latch, ser_data, done}, 0);
      chk(!chain_rst_n && busy, "R1 chain reset held", {chain_rst_n, busy}, 2'b01);
      rst_n = 1'b1;
      begin
         int n = 0;
         tick();
         while (!chain_rst_n) begin n++; tick(); end
         // released by the 50th edge after reset: 49 low samples before it
         chk(n == E_RST - 1, "R1 power-up hold length", n, E_RST - 1);
      end
      chk(!busy && !ser_clk && !ser_latch, "R1 R10 ready and idle",
          {busy, ser_clk, ser_latch}, 0);

      // Table of frames
      for (int i = 0; i < NV; i++) begin
         logic [FW-1:0] f;
         f = VEC[i][FW-1:0];
         while (busy) tick();
         clear_meas();
         frame_in = f; start = 1'b1;
         tick();
         start = 1'b0;
         chk(busy, "R8 busy after accept", busy, 1);
         if (VEC[i][FW]) begin
            repeat (300) tick();
            frame_in = ~f; start = 1'b1;   // R9 R11 disturbance
            tick();
            start = 1'b0;
         end
         while (!done) tick();
         check_frame(f);
         repeat (60) tick();
         chk(!busy && rises == FW, "R9 no extra frame", rises, FW);
         chk(!ser_clk && !ser_latch, "R10 idle lines", {ser_clk, ser_latch}, 0);
      end

      // R12: start held across the end of a frame
      clear_meas();
      frame_in = 24'h3C96E1; start = 1'b1;
      tick();
      frame_in = 24'hC3691E;
      while (!done) tick();
      check_frame(24'h3C96E1);
      clear_meas();
      tick();
      chk(busy, "R12 start in done cycle accepted", busy, 1);
      start = 1'b0;
      while (!done) tick();
      check_frame(24'hC3691E);

      summary();
      $finish;
   end

endmodule